// File: doc/BRIEF.md
# Buffered-Duty Eight-Bit PWM Timer

This block produces one pulse-width modulated output from an 8-bit counter. A selectable prescaler divides the system clock into count ticks. The counter steps once per tick from 0 up to 249 and then wraps back to 0, so one output period is always 250 ticks long. The output is at its active level from the wrap until the counter reaches the programmed duty value. It then drops to its inactive level for the rest of the period. A polarity bit swaps the two levels without changing any timing.

Software writes two registers through a simple write port. The control register holds the run bit, the polarity bit and the clock-select code. The duty register holds the compare value. While the timer is stopped, the counter sits at 0 and the output is forced low. A flag tells the pin multiplexer to give the pin back to general-purpose I/O, and a duty write becomes the active compare value at once. While the timer runs, a duty write waits in a buffer and is copied into the compare register only as the counter wraps from 249 to 0. Because of this, a period never mixes the old duty value with the new one.

Top module: `pwm8_timer`

## Requirements
- R1: Control register writes use `wr_sel`=0: bit 7 is run, bit 6 is polarity and bits 2:0 are the clock-select code. Codes 0 to 7 give one count tick every 2, 8, 32, 128, 256, 1024, 2048 and 4096 system clocks respectively. The first tick comes that many clocks after the timer starts running.
- R2: While running, the counter advances by one on each tick from 0 to 249 (0xF9) and wraps to 0 on the next tick, so one period is 250 ticks.
- R3: While run is 0, the counter is held at 0, `pwm_out` is 0 and `pin_owned` is 0. `pin_owned` follows the run bit one clock after a control write.
- R4: A duty write (`wr_sel`=1, value on `wr_data`) made while run is 0 becomes the active compare value at once.
- R5: In the first clock after run is set, `pin_owned` is 1 and, with positive polarity and a non-zero duty value, `pwm_out` is 1.
- R6: With positive polarity, the output level is 1 while the counter is below the active duty value and 0 from the tick where the counter equals the duty value until the wrap. A duty value D therefore gives 2·D high clocks per 500-clock period at code 0.
- R7: A duty write made while running is held in a buffer. It becomes active only on the tick where the counter steps from 249 to 0. Later writes before that tick replace the buffered value.
- R8: When the polarity bit is 1, `pwm_out` is the inverse of the positive-polarity level, with identical timing.
- R9: With positive polarity, a duty value of 0 gives a constant 0, and any duty value of 250 (0xFA) or more gives a constant 1 while running.
- R10: A control write that changes the clock-select code restarts the divider from zero. The next tick then arrives a full new division after the write, with no shortened interval.
- R11: After reset, run, polarity, clock select, the counter, the duty buffer and the active duty value are all 0, so `pwm_out` and `pin_owned` are 0.
- R12: `pwm_out` changes exactly one system clock after the clock in which the tick that causes a compare or a wrap occurs. It changes at no other time, except after a control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one clock per write |
| wr_sel | input | 1 | Register select: 0 control, 1 duty |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM output, 0 while stopped |
| pin_owned | output | 1 | 1 while the timer owns the pin, 0 when the pin belongs to general-purpose I/O |

## Verification
Every register in this block updates on the clock edge that samples a write or a tick. A control or duty write driven before edge k therefore shows on `pin_owned` and `pwm_out` right after edge k. A compare or wrap caused by a tick in the clock ending at edge k shows on `pwm_out` after that same edge. The bench drives inputs on the falling edge and advances a behavioural reference model on each rising edge. It compares both outputs with the model on every falling edge, so each result is checked in the exact clock it is due. Directed checks count high clocks over whole periods and measure the spacing between output edges to confirm the duty ratio, the buffered load and the divider restart.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;

    localparam int CNT_W    = 8;
    localparam int PERIOD   = 250;
    localparam int SEL_W    = 3;
    localparam int DIV_W    = 12;
    localparam int RUN_BIT  = 7;
    localparam int POL_BIT  = 6;

    typedef struct packed {
        logic             run;
        logic             pol;
        logic [SEL_W-1:0] sel;
    } ctrl_t;

    // Divisor exponent for each clock-select code.
    function automatic int unsigned div_shift(input logic [SEL_W-1:0] code);
        case (code)
            3'd0:    div_shift = 1;
            3'd1:    div_shift = 3;
            3'd2:    div_shift = 5;
            3'd3:    div_shift = 7;
            3'd4:    div_shift = 8;
            3'd5:    div_shift = 10;
            3'd6:    div_shift = 11;
            default: div_shift = 12;
        endcase
    endfunction

endpackage

// File: rtl/pwm8_prescaler.sv
module pwm8_prescaler
    import pwm8_pkg::*;
#(
    parameter int DIVW = DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIVW-1:0] div;
    } pre_t;

    pre_t            pre_d, pre_q;
    logic [DIVW-1:0] limit;

    always_comb begin
        limit  = DIVW'((64'd1 << div_shift(sel_i)) - 64'd1);
        tick_o = run_i && (pre_q.div == limit);
        pre_d  = pre_q;
        if (!run_i || restart_i || tick_o) begin
            pre_d.div = '0;
        end else begin
            pre_d.div = pre_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

endmodule

// File: rtl/pwm8_core.sv
module pwm8_core
    import pwm8_pkg::*;
#(
    parameter int CW  = CNT_W,
    parameter int PER = PERIOD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          tick_i,
    input  logic          duty_we_i,
    input  logic [CW-1:0] duty_i,
    output logic          lvl_o,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] act_o
);

    localparam logic [CW-1:0] LAST = CW'(PER - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] act;
        logic [CW-1:0] pend;
        logic          lvl;
    } core_t;

    core_t core_d, core_q;

    always_comb begin
        core_d = core_q;
        if (duty_we_i) begin
            core_d.pend = duty_i;
        end
        if (!run_i) begin
            core_d.cnt = '0;
            core_d.act = core_d.pend;
            core_d.lvl = (core_d.act != '0);
        end else if (tick_i) begin
            if (core_q.cnt == LAST) begin
                core_d.cnt = '0;
                core_d.act = core_d.pend;
            end else begin
                core_d.cnt = core_q.cnt + 1'b1;
            end
            core_d.lvl = (core_d.cnt < core_d.act);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign lvl_o = core_q.lvl;
    assign cnt_o = core_q.cnt;
    assign act_o = core_q.act;

endmodule

// File: rtl/pwm8_timer.sv
module pwm8_timer
    import pwm8_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    output logic       pwm_out,
    output logic       pin_owned
);

    ctrl_t            ctrl_d, ctrl_q;
    logic             ctrl_we;
    logic             restart;
    logic             tick;
    logic             lvl;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] act_w;
    logic             run_w;
    logic             pol_w;

    always_comb begin
        ctrl_we = wr_en && !wr_sel;
        restart = ctrl_we && (wr_data[SEL_W-1:0] != ctrl_q.sel);
        ctrl_d  = ctrl_q;
        if (ctrl_we) begin
            ctrl_d.run = wr_data[RUN_BIT];
            ctrl_d.pol = wr_data[POL_BIT];
            ctrl_d.sel = wr_data[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    pwm8_prescaler #(.DIVW(DIV_W)) i_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (ctrl_q.run),
        .restart_i (restart),
        .sel_i     (ctrl_q.sel),
        .tick_o    (tick)
    );

    pwm8_core #(.CW(CNT_W), .PER(PERIOD)) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (ctrl_q.run),
        .tick_i    (tick),
        .duty_we_i (wr_en && wr_sel),
        .duty_i    (wr_data[CNT_W-1:0]),
        .lvl_o     (lvl),
        .cnt_o     (cnt_w),
        .act_o     (act_w)
    );

    assign run_w     = ctrl_q.run;
    assign pol_w     = ctrl_q.pol;
    assign pwm_out   = ctrl_q.run & (lvl ^ ctrl_q.pol);
    assign pin_owned = ctrl_q.run;

endmodule

// File: rtl/pwm8_timer_checker.sv
module pwm8_timer_checker #(
    parameter int CW  = 8,
    parameter int PER = 250
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          pol,
    input logic          tick,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] act,
    input logic          pwm_out,
    input logic          pin_owned
);

    localparam logic [CW-1:0] LAST = CW'(PER - 1);

    a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    a_r3_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

    a_r3_pin_released: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_owned |-> !pwm_out);

    a_r1_tick_running: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run);

    a_r7_load_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && (act != $past(act))) |-> ((cnt == '0) && ($past(cnt) == LAST)));

    a_r12_out_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $stable(pol) && !$past(tick)) |-> $stable(pwm_out));

endmodule

bind pwm8_timer pwm8_timer_checker #(.CW(pwm8_pkg::CNT_W), .PER(pwm8_pkg::PERIOD)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_w),
    .pol       (pol_w),
    .tick      (tick),
    .cnt       (cnt_w),
    .act       (act_w),
    .pwm_out   (pwm_out),
    .pin_owned (pin_owned)
);

// File: tb/test_pwm8_timer.sv
`timescale 1ns/1ps
module test_pwm8_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       pwm_out;
    logic       pin_owned;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles = 0;
    bit    cmp_on = 1'b0;
    string tag = "R11";

    // reference model state
    bit m_run, m_pol;
    int m_sel, m_div, m_cnt, m_act, m_pend;
    bit m_lvl;

    always #5 clk = ~clk;

    pwm8_timer i_pwm8_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pwm_out(pwm_out), .pin_owned(pin_owned)
    );

    function automatic int divisor(input int code);
        case (code)
            0: return 2;     1: return 8;     2: return 32;    3: return 128;
            4: return 256;   5: return 1024;  6: return 2048;  default: return 4096;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    function automatic bit exp_out();
        return m_run ? (m_lvl ^ m_pol) : 1'b0;
    endfunction

    always @(posedge clk) begin
        bit tick, restart;
        int pend_n, act_n, cnt_n;
        bit lvl_n;
        cycles <= cycles + 1;
        if (!rst_n) begin
            m_run <= 0; m_pol <= 0; m_sel <= 0; m_div <= 0;
            m_cnt <= 0; m_act <= 0; m_pend <= 0; m_lvl <= 0;
        end else begin
            tick    = m_run && (m_div == divisor(m_sel) - 1);
            restart = wr_en && !wr_sel && (int'(wr_data[2:0]) != m_sel);
            m_div  <= (!m_run || restart || tick) ? 0 : m_div + 1;
            pend_n  = (wr_en && wr_sel) ? int'(wr_data) : m_pend;
            act_n = m_act; cnt_n = m_cnt; lvl_n = m_lvl;
            if (!m_run) begin
                cnt_n = 0; act_n = pend_n; lvl_n = (act_n > 0);
            end else if (tick) begin
                if (m_cnt == 249) begin cnt_n = 0; act_n = pend_n; end
                else cnt_n = m_cnt + 1;
                lvl_n = (cnt_n < act_n);
            end
            m_pend <= pend_n; m_act <= act_n; m_cnt <= cnt_n; m_lvl <= lvl_n;
            if (wr_en && !wr_sel) begin
                m_run <= wr_data[7]; m_pol <= wr_data[6]; m_sel <= int'(wr_data[2:0]);
            end
        end
    end

    // cycle-by-cycle comparison with the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            check(pwm_out == exp_out(), {tag, "/R12 pwm_out"}, pwm_out, exp_out());
            check(pin_owned == m_run, {tag, " pin_owned"}, pin_owned, m_run);
        end
    end

    always @(negedge clk) begin
        if (cycles > 190000) begin
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic wr(input bit sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00;
    endtask

    task automatic wr_ctrl(input bit run, input bit pol, input int sel);
        wr(1'b0, {run, pol, 3'b000, 3'(sel)});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // counts high clocks over n samples taken on falling edges
    task automatic count_high(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out) highs++;
            @(negedge clk);
        end
    endtask

    initial begin
        int h;
        int t0;
        repeat (3) @(negedge clk);
        check(pwm_out == 1'b0, "R11 reset pwm_out", pwm_out, 0);
        check(pin_owned == 1'b0, "R11 reset pin_owned", pin_owned, 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        idle(4);

        tag = "R4";
        wr(1'b1, 8'd100);
        wr(1'b1, 8'd120);
        tag = "R5";
        // enable write; the sample after the write edge is the first owned clock
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h80;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
        check(pin_owned == 1'b1, "R5 owned after run", pin_owned, 1);
        check(pwm_out == 1'b1, "R5 high after run", pwm_out, 1);
        tag = "R6";
        count_high(500, h);
        check(h == 240, "R4/R6 high clocks duty 120", h, 240);
        count_high(500, h);
        check(h == 240, "R2 second period", h, 240);

        tag = "R7";
        idle(100);
        wr(1'b1, 8'd30);
        wr(1'b1, 8'd50);
        idle(900);

        tag = "R8";
        wr_ctrl(1'b1, 1'b1, 0);
        idle(1100);
        wr_ctrl(1'b1, 1'b0, 0);

        tag = "R9";
        wr(1'b1, 8'd0);
        idle(600);
        count_high(500, h);
        check(h == 0, "R9 duty 0 constant low", h, 0);
        wr(1'b1, 8'hFA);
        idle(600);
        count_high(500, h);
        check(h == 500, "R9 duty 0xFA constant high", h, 500);
        wr(1'b1, 8'hFF);
        idle(600);
        count_high(500, h);
        check(h == 500, "R9 duty 0xFF constant high", h, 500);

        tag = "R10";
        wr(1'b1, 8'd10);
        idle(300);
        wr_ctrl(1'b1, 1'b0, 1);
        idle(4100);
        wr_ctrl(1'b1, 1'b0, 2);
        idle(8100);

        tag = "R3";
        wr_ctrl(1'b0, 1'b0, 2);
        check(pin_owned == 1'b0, "R3 released", pin_owned, 0);
        check(pwm_out == 1'b0, "R3 output off", pwm_out, 0);
        idle(50);
        wr(1'b1, 8'd1);

        tag = "R1";
        // code 0: first high-to-low edge comes after one tick of 2 clocks
        wr_ctrl(1'b1, 1'b0, 0);
        t0 = 0;
        while (pwm_out && t0 < 100) begin @(negedge clk); t0++; end
        check(t0 == 2, "R1 tick spacing code 0", t0, 2);
        wr_ctrl(1'b0, 1'b0, 0);
        wr_ctrl(1'b1, 1'b0, 3);
        t0 = 0;
        while (pwm_out && t0 < 1000) begin @(negedge clk); t0++; end
        check(t0 == 128, "R1 tick spacing code 3", t0, 128);
        idle(3000);
        wr_ctrl(1'b0, 1'b0, 7);
        wr_ctrl(1'b1, 1'b0, 7);
        t0 = 0;
        while (pwm_out && t0 < 9000) begin @(negedge clk); t0++; end
        check(t0 == 4096, "R1 tick spacing code 7", t0, 4096);
        idle(9000);

        cmp_on = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule